// File: doc/BRIEF.md
# Dual-Slot Store Commit Unit

This unit takes the buffered stores of one packet and turns them into writes on a 64-bit data memory port with byte enables. A packet carries up to two store slots. Each slot holds an address, a width in bytes and the store data. Stores of up to 4 bytes carry their data in a 32-bit field, and 8-byte stores carry it in a 64-bit field. The unit drops predicated slots whose cancel bit is set. It skips slot 1 when that store already went out earlier in the packet. It commits slot 1 ahead of slot 0, so that where the two overlap slot 0 leaves the final bytes. It rejects accesses that are not aligned to their width and reports them with an error flag.

A packet may instead carry a line-zero request. In that case every slot field is ignored and the unit clears one aligned 32-byte line with four full-width zero writes, in ascending address order.

The pipeline raises `commit_req` while the unit is idle. The unit samples all slot inputs on that edge, issues one write per cycle, and then pulses `done` for one cycle. The pulse carries the packet's error flag. Requests made while the unit is busy are ignored.

Top module: `store_commit_unit`

## Requirements
- R1: `commit_req` high at a clock edge while `busy` is low starts a packet. The slot inputs are sampled at that edge and `busy` is high from the next cycle until the cycle after `done`. A `commit_req` seen while `busy` is high is ignored and does not change the writes of the running packet.
- R2: A store width is a byte count, one of 1, 2, 4 or 8. Let lo be the address bits [2:0]. The write has `mem_addr` equal to the store address with bits [2:0] cleared, `mem_be` bits lo to lo+width-1 set, and the data bytes placed in those lanes. Widths up to 4 take the low bytes of the 32-bit field, and width 8 takes the 64-bit field. Lanes that are not enabled carry zero.
- R3: If a slot that would write has a width outside {1,2,4,8}, or lo is not a multiple of its width, that slot makes no write and `err` is high together with `done`. `err` is low with `done` for packets without such a slot.
- R4: When both slots write, the slot 1 write comes in the cycle before the slot 0 write.
- R5: A slot whose predicated bit is high and whose bit in `cancel_mask` is set makes no write and raises no error. `cancel_mask` bit 0 belongs to slot 0 and bit 1 to slot 1. A slot that is not predicated ignores its cancel bit.
- R6: When `s1_committed` is high, slot 1 makes no write and raises no error.
- R7: When `zero_line` is high, the packet makes exactly four writes. They go to A, A+8, A+16 and A+24 in that order, where A is `s0_addr` with bits [4:0] cleared, each with `mem_be` = 0xFF and data zero. All other slot, predicate and cancel inputs are ignored and `err` stays low.
- R8: Writes come one per cycle in consecutive cycles, starting the cycle after acceptance. `done` is high for exactly one cycle, the cycle after the last write, and in no cycle with a write. A packet with no writes gives `done` in the cycle after acceptance.
- R9: During and right after reset, `busy`, `done`, `err` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_req | input | 1 | Start commit of the current packet |
| busy | output | 1 | A packet is being committed |
| done | output | 1 | One-cycle pulse after the last write |
| err | output | 1 | Misaligned or illegal-width slot seen (valid with done) |
| s0_valid | input | 1 | Slot 0 holds a store |
| s0_pred | input | 1 | Slot 0 store is predicated |
| s0_addr | input | ADDR_W | Slot 0 byte address (also line address for line-zero) |
| s0_width | input | 4 | Slot 0 width in bytes |
| s0_data32 | input | 32 | Slot 0 data for widths up to 4 |
| s0_data64 | input | 64 | Slot 0 data for width 8 |
| s1_valid | input | 1 | Slot 1 holds a store |
| s1_pred | input | 1 | Slot 1 store is predicated |
| s1_addr | input | ADDR_W | Slot 1 byte address |
| s1_width | input | 4 | Slot 1 width in bytes |
| s1_data32 | input | 32 | Slot 1 data for widths up to 4 |
| s1_data64 | input | 64 | Slot 1 data for width 8 |
| s1_committed | input | 1 | Slot 1 store already written earlier in the packet |
| cancel_mask | input | 2 | Per-slot cancel bits (bit n is slot n) |
| zero_line | input | 1 | Packet is a line-zero operation |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | 8-byte aligned write address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data, lane aligned |

## Verification
The assertions rely on the pipeline never presenting a line-zero packet that also expects normal stores. This matters because the ordering property assumes each packet carries at most one slot 1 write and one slot 0 write. They also take for granted that `commit_req` is a level sampled only when the unit is idle. The stimulus therefore sets all slot inputs at the falling edge before the accepting edge. Its one deliberate exception is the busy-time request test, which changes `s0_addr` while `commit_req` stays high and drops the request in the `done` cycle, so that no second packet starts. The sweeps cover every width code, including an illegal one, at all eight byte offsets in each slot, and all sixteen predicate and cancel combinations.

// File: rtl/scu_pkg.sv
package scu_pkg;

  localparam int LANE_BYTES = 8;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_S0   = 2'd1,
    SRC_S1   = 2'd2,
    SRC_ZERO = 2'd3
  } scu_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } scu_state_e;

  // Width given as a byte count; only powers of two up to the lane size.
  function automatic logic scu_width_legal(input logic [3:0] w);
    return (w == 4'd1) || (w == 4'd2) || (w == 4'd4) || (w == 4'd8);
  endfunction

  // Legal width and offset a multiple of it.
  function automatic logic scu_fits(input logic [2:0] lo, input logic [3:0] w);
    return scu_width_legal(w) && (({1'b0, lo} & (w - 4'd1)) == 4'd0);
  endfunction

  function automatic logic [7:0] scu_lane_mask(input logic [2:0] lo, input logic [3:0] w);
    logic [7:0] m;
    case (w)
      4'd1:    m = 8'h01;
      4'd2:    m = 8'h03;
      4'd4:    m = 8'h0F;
      4'd8:    m = 8'hFF;
      default: m = 8'h00;
    endcase
    return m << lo;
  endfunction

  function automatic logic [63:0] scu_lane_data(input logic [2:0] lo, input logic [3:0] w,
                                                input logic [31:0] d32, input logic [63:0] d64);
    logic [63:0] raw;
    case (w)
      4'd1:    raw = {56'd0, d32[7:0]};
      4'd2:    raw = {48'd0, d32[15:0]};
      4'd4:    raw = {32'd0, d32};
      4'd8:    raw = d64;
      default: raw = 64'd0;
    endcase
    return raw << {lo, 3'b000};
  endfunction

endpackage

// File: rtl/scu_slot_decode.sv
module scu_slot_decode
  import scu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              st_valid,
  input  logic              st_pred,
  input  logic              st_cancel,
  input  logic              st_skip,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [3:0]        st_width,
  input  logic [31:0]       st_d32,
  input  logic [63:0]       st_d64,
  output logic              wr_go,
  output logic              wr_bad,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_be,
  output logic [63:0]       wr_data
);
  localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(LANE_BYTES - 1);

  logic live;
  logic fits;

  assign live    = st_valid && !(st_pred && st_cancel) && !st_skip;
  assign fits    = scu_fits(st_addr[2:0], st_width);
  assign wr_go   = live && fits;
  assign wr_bad  = live && !fits;
  assign wr_addr = st_addr & ~LANE_MASK;
  assign wr_be   = scu_lane_mask(st_addr[2:0], st_width);
  assign wr_data = scu_lane_data(st_addr[2:0], st_width, st_d32, st_d64);
endmodule

// File: rtl/scu_op_builder.sv
module scu_op_builder
  import scu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ZERO_BEATS = 4,
  parameter int MAX_OPS    = 4,
  parameter int CNT_W      = 3
) (
  input  logic [1:0]        go,
  input  logic [1:0]        bad,
  input  logic [ADDR_W-1:0] s0_waddr,
  input  logic [7:0]        s0_be,
  input  logic [63:0]       s0_data,
  input  logic [ADDR_W-1:0] s1_waddr,
  input  logic [7:0]        s1_be,
  input  logic [63:0]       s1_data,
  input  logic              zero_en,
  input  logic [ADDR_W-1:0] zero_addr,
  output logic [ADDR_W-1:0] op_addr [MAX_OPS],
  output logic [7:0]        op_be   [MAX_OPS],
  output logic [63:0]       op_data [MAX_OPS],
  output scu_src_e          op_src  [MAX_OPS],
  output logic [CNT_W-1:0]  op_cnt,
  output logic              pkt_err
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] line_base;
  assign line_base = zero_addr & ~LINE_MASK;

  always_comb begin
    for (int i = 0; i < MAX_OPS; i++) begin
      op_addr[i] = '0;
      op_be[i]   = '0;
      op_data[i] = '0;
      op_src[i]  = SRC_NONE;
    end
    op_cnt  = '0;
    pkt_err = 1'b0;
    if (zero_en) begin
      for (int i = 0; i < ZERO_BEATS; i++) begin
        op_addr[i] = line_base + ADDR_W'(i * LANE_BYTES);
        op_be[i]   = 8'hFF;
        op_data[i] = 64'd0;
        op_src[i]  = SRC_ZERO;
      end
      op_cnt = CNT_W'(ZERO_BEATS);
    end else begin
      // Slot 1 goes first so slot 0 owns any overlapping bytes.
      if (go[1]) begin
        op_addr[0] = s1_waddr;
        op_be[0]   = s1_be;
        op_data[0] = s1_data;
        op_src[0]  = SRC_S1;
        if (go[0]) begin
          op_addr[1] = s0_waddr;
          op_be[1]   = s0_be;
          op_data[1] = s0_data;
          op_src[1]  = SRC_S0;
        end
      end else if (go[0]) begin
        op_addr[0] = s0_waddr;
        op_be[0]   = s0_be;
        op_data[0] = s0_data;
        op_src[0]  = SRC_S0;
      end
      op_cnt  = CNT_W'(go[0]) + CNT_W'(go[1]);
      pkt_err = |bad;
    end
  end
endmodule

// File: rtl/scu_sequencer.sv
module scu_sequencer
  import scu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_OPS = 4,
  parameter int CNT_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] in_addr [MAX_OPS],
  input  logic [7:0]        in_be   [MAX_OPS],
  input  logic [63:0]       in_data [MAX_OPS],
  input  scu_src_e          in_src  [MAX_OPS],
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic              in_err,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_be,
  output logic [63:0]       wr_data,
  output scu_src_e          wr_src,
  output logic              done,
  output logic              err,
  output logic              busy
);
  scu_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q [MAX_OPS];
  logic [7:0]        be_q   [MAX_OPS];
  logic [63:0]       data_q [MAX_OPS];
  scu_src_e          src_q  [MAX_OPS];
  logic              last_beat;

  assign last_beat = (idx == IDX_W'(cnt_q - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < MAX_OPS; i++) begin
        addr_q[i] <= '0;
        be_q[i]   <= '0;
        data_q[i] <= '0;
        src_q[i]  <= SRC_NONE;
      end
    end else begin
      case (state)
        ST_IDLE: if (start_req) begin
          for (int i = 0; i < MAX_OPS; i++) begin
            addr_q[i] <= in_addr[i];
            be_q[i]   <= in_be[i];
            data_q[i] <= in_data[i];
            src_q[i]  <= in_src[i];
          end
          cnt_q <= in_cnt;
          err_q <= in_err;
          idx   <= '0;
          state <= (in_cnt == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (last_beat) state <= ST_DONE;
          else           idx   <= idx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_en   = (state == ST_RUN);
  assign wr_addr = wr_en ? addr_q[idx] : '0;
  assign wr_be   = wr_en ? be_q[idx]   : '0;
  assign wr_data = wr_en ? data_q[idx] : '0;
  assign wr_src  = wr_en ? src_q[idx]  : SRC_NONE;
  assign done    = (state == ST_DONE);
  assign err     = done && err_q;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/store_commit_unit.sv
module store_commit_unit
  import scu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_req,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              s0_valid,
  input  logic              s0_pred,
  input  logic [ADDR_W-1:0] s0_addr,
  input  logic [3:0]        s0_width,
  input  logic [31:0]       s0_data32,
  input  logic [63:0]       s0_data64,
  input  logic              s1_valid,
  input  logic              s1_pred,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [3:0]        s1_width,
  input  logic [31:0]       s1_data32,
  input  logic [63:0]       s1_data64,
  input  logic              s1_committed,
  input  logic [1:0]        cancel_mask,
  input  logic              zero_line,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata
);
  localparam int NUM_SLOTS  = 2;
  localparam int ZERO_BEATS = LINE_BYTES / LANE_BYTES;
  localparam int MAX_OPS    = (ZERO_BEATS > NUM_SLOTS) ? ZERO_BEATS : NUM_SLOTS;
  localparam int CNT_W      = $clog2(MAX_OPS + 1);
  localparam int IDX_W      = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1;

  // Per-slot views of the store log.
  logic              sl_valid [NUM_SLOTS];
  logic              sl_pred  [NUM_SLOTS];
  logic              sl_skip  [NUM_SLOTS];
  logic [ADDR_W-1:0] sl_addr  [NUM_SLOTS];
  logic [3:0]        sl_width [NUM_SLOTS];
  logic [31:0]       sl_d32   [NUM_SLOTS];
  logic [63:0]       sl_d64   [NUM_SLOTS];

  assign sl_valid = '{s0_valid, s1_valid};
  assign sl_pred  = '{s0_pred, s1_pred};
  assign sl_skip  = '{1'b0, s1_committed};
  assign sl_addr  = '{s0_addr, s1_addr};
  assign sl_width = '{s0_width, s1_width};
  assign sl_d32   = '{s0_data32, s1_data32};
  assign sl_d64   = '{s0_data64, s1_data64};

  // Named per-slot events, visible to the checker.
  logic [NUM_SLOTS-1:0] slot_go;
  logic [NUM_SLOTS-1:0] slot_bad;
  logic [ADDR_W-1:0]    slot_waddr [NUM_SLOTS];
  logic [7:0]           slot_be    [NUM_SLOTS];
  logic [63:0]          slot_data  [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    scu_slot_decode #(.ADDR_W(ADDR_W)) dec_i (
      .st_valid (sl_valid[g]),
      .st_pred  (sl_pred[g]),
      .st_cancel(cancel_mask[g]),
      .st_skip  (sl_skip[g]),
      .st_addr  (sl_addr[g]),
      .st_width (sl_width[g]),
      .st_d32   (sl_d32[g]),
      .st_d64   (sl_d64[g]),
      .wr_go    (slot_go[g]),
      .wr_bad   (slot_bad[g]),
      .wr_addr  (slot_waddr[g]),
      .wr_be    (slot_be[g]),
      .wr_data  (slot_data[g])
    );
  end

  logic [ADDR_W-1:0] op_addr [MAX_OPS];
  logic [7:0]        op_be   [MAX_OPS];
  logic [63:0]       op_data [MAX_OPS];
  scu_src_e          op_src  [MAX_OPS];
  logic [CNT_W-1:0]  op_cnt;
  logic              op_err;

  scu_op_builder #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ZERO_BEATS(ZERO_BEATS),
    .MAX_OPS(MAX_OPS), .CNT_W(CNT_W)
  ) build_i (
    .go       (slot_go),
    .bad      (slot_bad),
    .s0_waddr (slot_waddr[0]),
    .s0_be    (slot_be[0]),
    .s0_data  (slot_data[0]),
    .s1_waddr (slot_waddr[1]),
    .s1_be    (slot_be[1]),
    .s1_data  (slot_data[1]),
    .zero_en  (zero_line),
    .zero_addr(s0_addr),
    .op_addr  (op_addr),
    .op_be    (op_be),
    .op_data  (op_data),
    .op_src   (op_src),
    .op_cnt   (op_cnt),
    .pkt_err  (op_err)
  );

  scu_src_e seq_src;

  scu_sequencer #(
    .ADDR_W(ADDR_W), .MAX_OPS(MAX_OPS), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(commit_req),
    .in_addr  (op_addr),
    .in_be    (op_be),
    .in_data  (op_data),
    .in_src   (op_src),
    .in_cnt   (op_cnt),
    .in_err   (op_err),
    .wr_en    (mem_wr_en),
    .wr_addr  (mem_addr),
    .wr_be    (mem_be),
    .wr_data  (mem_wdata),
    .wr_src   (seq_src),
    .done     (done),
    .err      (err),
    .busy     (busy)
  );
endmodule

// File: rtl/scu_checker.sv
module scu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_req,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_be,
  input logic [63:0]       mem_wdata,
  input logic [1:0]        wr_src
);
  localparam logic [1:0] K_S0   = 2'd1;
  localparam logic [1:0] K_S1   = 2'd2;
  localparam logic [1:0] K_ZERO = 2'd3;

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !busy) |=> busy);

  assert_lane_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr[2:0] == 3'd0) &&
      ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
       $countones(mem_be) == 4 || $countones(mem_be) == 8));

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && wr_src == K_S0) |=> !(mem_wr_en && wr_src == K_S1));

  assert_zero_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && wr_src == K_ZERO) |-> (mem_be == 8'hFF) && (mem_wdata == 64'd0) && !err);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_wr_en);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_wr_en && !done && !err);
endmodule

bind store_commit_unit scu_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .commit_req(commit_req),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_wr_en (mem_wr_en),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .wr_src    (seq_src)
);

// File: tb/store_commit_unit_tb_top.sv
`timescale 1ns/1ps
module store_commit_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit_req = 1'b0;
  logic        busy, done, err;
  logic        s0_valid, s0_pred, s1_valid, s1_pred, s1_committed, zero_line;
  logic [31:0] s0_addr, s1_addr, s0_data32, s1_data32;
  logic [3:0]  s0_width, s1_width;
  logic [63:0] s0_data64, s1_data64;
  logic [1:0]  cancel_mask;
  logic        mem_wr_en;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;

  always #4 clk = ~clk;

  store_commit_unit dut_i (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .busy(busy), .done(done), .err(err),
    .s0_valid(s0_valid), .s0_pred(s0_pred), .s0_addr(s0_addr), .s0_width(s0_width),
    .s0_data32(s0_data32), .s0_data64(s0_data64),
    .s1_valid(s1_valid), .s1_pred(s1_pred), .s1_addr(s1_addr), .s1_width(s1_width),
    .s1_data32(s1_data32), .s1_data64(s1_data64), .s1_committed(s1_committed),
    .cancel_mask(cancel_mask), .zero_line(zero_line),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] e_addr [8];
  logic [7:0]  e_be   [8];
  logic [63:0] e_data [8];
  int          e_n;
  bit          e_err;
  logic [31:0] g_addr [8];
  logic [7:0]  g_be   [8];
  logic [63:0] g_data [8];
  int          g_n;
  bit          g_err;
  int          g_done_cyc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    s0_valid = 0; s0_pred = 0; s0_addr = 0; s0_width = 4'd1; s0_data32 = 0; s0_data64 = 0;
    s1_valid = 0; s1_pred = 0; s1_addr = 0; s1_width = 4'd1; s1_data32 = 0; s1_data64 = 0;
    s1_committed = 0; cancel_mask = 0; zero_line = 0;
  endtask

  // Expected write for one slot, restated from the byte-lane rules.
  task automatic expect_slot(input bit v, input bit p, input bit c, input bit skip,
                             input logic [31:0] a, input logic [3:0] w,
                             input logic [31:0] d32, input logic [63:0] d64);
    int lo;
    int wi;
    logic [63:0] src;
    logic [63:0] dat;
    logic [7:0]  be;
    if (!v || (p && c) || skip) return;
    lo = int'(a % 8);
    wi = int'(w);
    if (!(wi == 1 || wi == 2 || wi == 4 || wi == 8) || (lo % wi) != 0) begin
      e_err = 1;
      return;
    end
    src = (wi == 8) ? d64 : {32'd0, d32};
    be  = 8'h00;
    dat = 64'd0;
    for (int b = 0; b < 8; b++)
      if (b >= lo && b < lo + wi) begin
        be[b] = 1'b1;
        dat[8*b +: 8] = src[8*(b-lo) +: 8];
      end
    e_addr[e_n] = a - 32'(lo);
    e_be[e_n]   = be;
    e_data[e_n] = dat;
    e_n++;
  endtask

  task automatic build_expected();
    e_n = 0;
    e_err = 0;
    if (zero_line) begin
      for (int k = 0; k < 4; k++) begin
        e_addr[k] = (s0_addr / 32) * 32 + 32'(8 * k);
        e_be[k]   = 8'hFF;
        e_data[k] = 64'd0;
      end
      e_n = 4;
    end else begin
      expect_slot(s1_valid, s1_pred, cancel_mask[1], s1_committed, s1_addr, s1_width, s1_data32, s1_data64);
      expect_slot(s0_valid, s0_pred, cancel_mask[0], 1'b0, s0_addr, s0_width, s0_data32, s0_data64);
    end
  endtask

  // Samples from the first falling edge after acceptance until done.
  task automatic collect(input bit drop_req_at_done);
    g_n = 0;
    g_err = 0;
    g_done_cyc = -1;
    for (int cyc = 0; cyc < 12; cyc++) begin
      if (mem_wr_en && g_n < 8) begin
        g_addr[g_n] = mem_addr;
        g_be[g_n]   = mem_be;
        g_data[g_n] = mem_wdata;
        g_n++;
      end
      if (done) begin
        g_err = err;
        g_done_cyc = cyc;
        if (drop_req_at_done) commit_req = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic compare(input string req);
    check(g_done_cyc >= 0, "R8", {req, " done seen"}, 64'(g_done_cyc), 64'(e_n));
    check(g_done_cyc == e_n, "R8", {req, " done cycle"}, 64'(g_done_cyc), 64'(e_n));
    check(g_n == e_n, req, "write count", 64'(g_n), 64'(e_n));
    for (int i = 0; i < e_n && i < g_n; i++) begin
      check(g_addr[i] == e_addr[i], req, "addr", 64'(g_addr[i]), 64'(e_addr[i]));
      check(g_be[i] == e_be[i], req, "byte enables", 64'(g_be[i]), 64'(e_be[i]));
      check(g_data[i] == e_data[i], req, "data", g_data[i], e_data[i]);
    end
    check(g_err == e_err, "R3", {req, " err flag"}, 64'(g_err), 64'(e_err));
  endtask

  // Inputs are already set; accept on the next rising edge.
  task automatic run_packet(input string req);
    build_expected();
    @(negedge clk);
    commit_req = 1;
    @(posedge clk);
    @(negedge clk);
    commit_req = 0;
    collect(1'b0);
    compare(req);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    automatic int widths[5] = '{1, 2, 3, 4, 8};
    idle_inputs();
    repeat (3) @(negedge clk);
    // R9: quiet during reset
    check(!busy && !done && !err && !mem_wr_en, "R9", "outputs in reset",
          {busy, done, err, mem_wr_en}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !err && !mem_wr_en, "R9", "outputs after reset",
          {busy, done, err, mem_wr_en}, 64'd0);

    // R8: empty packet
    run_packet("R8 empty");

    // R2/R3: every width code at every offset, each slot alone
    for (int wi = 0; wi < 5; wi++)
      for (int lo = 0; lo < 8; lo++) begin
        idle_inputs();
        s0_valid = 1; s0_width = 4'(widths[wi]); s0_addr = 32'h1000_0040 + 32'(lo);
        s0_data32 = 32'hA1B2_C3D4 ^ 32'(lo * 16'h0101);
        s0_data64 = 64'h1122_3344_5566_7788 + 64'(lo);
        run_packet("R2/R3 slot0");
        idle_inputs();
        s1_valid = 1; s1_width = 4'(widths[wi]); s1_addr = 32'h0000_8F08 + 32'(lo);
        s1_data32 = 32'h5E6F_7081 + 32'(wi);
        s1_data64 = 64'hF0E1_D2C3_B4A5_9687 ^ 64'(lo << 8);
        run_packet("R2/R3 slot1");
      end

    // R4: overlapping stores, slot 1 first
    idle_inputs();
    s1_valid = 1; s1_width = 4'd8; s1_addr = 32'h200; s1_data64 = 64'hAAAA_BBBB_CCCC_DDDD;
    s0_valid = 1; s0_width = 4'd2; s0_addr = 32'h202; s0_data32 = 32'h0000_1234;
    run_packet("R4 overlap");
    idle_inputs();
    s1_valid = 1; s1_width = 4'd4; s1_addr = 32'h304; s1_data32 = 32'hCAFE_0001;
    s0_valid = 1; s0_width = 4'd1; s0_addr = 32'h417; s0_data32 = 32'h0000_00EE;
    run_packet("R4 disjoint");
    idle_inputs();
    s1_valid = 1; s1_width = 4'd2; s1_addr = 32'h501; s1_data32 = 32'h1;
    s0_valid = 1; s0_width = 4'd4; s0_addr = 32'h508; s0_data32 = 32'h7777_8888;
    run_packet("R4 slot1 misaligned");

    // R5: predicate and cancel matrix
    for (int m = 0; m < 16; m++) begin
      idle_inputs();
      s0_valid = 1; s0_width = 4'd4; s0_addr = 32'h700; s0_data32 = 32'h0BAD_F00D + 32'(m);
      s1_valid = 1; s1_width = 4'd2; s1_addr = 32'h806; s1_data32 = 32'h0000_4321;
      s0_pred = m[0]; cancel_mask[0] = m[1]; s1_pred = m[2]; cancel_mask[1] = m[3];
      run_packet("R5 cancel");
    end
    idle_inputs();
    s0_valid = 1; s0_pred = 1; s0_width = 4'd2; s0_addr = 32'h901; cancel_mask = 2'b01;
    run_packet("R5 cancelled misaligned");

    // R6: slot 1 already committed
    idle_inputs();
    s1_valid = 1; s1_committed = 1; s1_width = 4'd4; s1_addr = 32'hA00; s1_data32 = 32'h1111_2222;
    s0_valid = 1; s0_width = 4'd8; s0_addr = 32'hA08; s0_data64 = 64'h3333_4444_5555_6666;
    run_packet("R6 with slot0");
    idle_inputs();
    s1_valid = 1; s1_committed = 1; s1_width = 4'd1; s1_addr = 32'hA13; s1_data32 = 32'h99;
    run_packet("R6 alone");

    // R7: line zero with other fields set to noise
    for (int z = 0; z < 4; z++) begin
      idle_inputs();
      zero_line = 1;
      s0_addr = (z == 0) ? 32'h2000_0013 : (z == 1) ? 32'h2000_001F :
                (z == 2) ? 32'h2000_0000 : 32'hFFFF_FFE7;
      s0_valid = 1; s0_pred = 1; s0_width = 4'd3; s0_data32 = 32'hFFFF_FFFF;
      s1_valid = 1; s1_width = 4'd8; s1_addr = 32'h2000_0008; s1_data64 = '1;
      cancel_mask = 2'(z);
      run_packet("R7 zero line");
    end

    // R1: request held while busy with changed fields is ignored
    idle_inputs();
    s1_valid = 1; s1_width = 4'd4; s1_addr = 32'hB00; s1_data32 = 32'h0123_4567;
    s0_valid = 1; s0_width = 4'd2; s0_addr = 32'hB0A; s0_data32 = 32'h0000_89AB;
    build_expected();
    @(negedge clk);
    commit_req = 1;
    @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R1", "busy after accept", 64'(busy), 64'd1);
    s0_addr = 32'hC00;
    s0_width = 4'd8;
    collect(1'b1);
    compare("R1 busy request");
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      check(!mem_wr_en && !done && !busy, "R1", "no second packet",
            {mem_wr_en, done, busy}, 64'd0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule